// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Arbiter

This block sits between a set of level-sensitive interrupt request lines and a CPU core. Each source owns a programmable priority level held in software-written registers. Every cycle the arbiter picks the highest-level request that is active and not masked. It compares that level against the CPU's current mask level. If the level is strictly higher, it raises a single request to the CPU together with the winner's level and an event code. The CPU latches that code to identify the source.

Software writes the registers through a simple write port. Priority words pack several 4-bit levels per word. One address sets per-source mask bits wherever a 1 is written. A second address clears mask bits wherever a 1 is written. Requests that lose arbitration are not consumed: a source keeps competing until its line drops.

Top module: `intc_arbiter`

## Requirements
- R1: Among sources whose request line is high, whose mask bit is 0 and whose priority is nonzero, the one with the highest priority level wins.
- R2: When two or more eligible sources share the highest level, the source with the lower index wins.
- R3: A losing request is kept pending; once the winner's line drops, the pending source wins on the next evaluation.
- R4: `cpu_req` is raised only when the winner's level is strictly greater than `cpu_mask_lvl`. Otherwise `cpu_req`, `cpu_lvl` and `cpu_code` are all 0.
- R5: `cpu_code` equals CODE_BASE + CODE_STEP × winner index (defaults 0x200 and 0x20), and `cpu_lvl` equals the winner's level.
- R6: A write to address PRI_WORDS (the mask-set register) sets every mask bit whose data bit is 1. Bits written 0 keep their value. A masked source never wins.
- R7: A source whose priority level is 0 never wins, whatever its request line does.
- R8: A write to address PRI_WORDS+1 (the mask-clear register) clears every mask bit whose data bit is 1. Writing 0 to a bit has no effect on it.
- R9: Outputs are registered. A change on `irq_req` or `cpu_mask_lvl` shows on the outputs after the next rising edge, not before. A register write takes effect on the outputs one edge after the edge that performs the write.
- R10: While `rst_n` is low, and after it is released, all priorities read as 0, all mask bits are 0 and all outputs are 0.
- R11: The level of source i lives in write address i / (DATA_W/4), bits [4·(i mod (DATA_W/4)) +: 4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Level-sensitive request lines, bit i is source i |
| cpu_mask_lvl | input | LVL_W | CPU mask level; requests must exceed it |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_lvl | output | LVL_W | Level of the forwarded source |
| cpu_code | output | CODE_W | Event code of the forwarded source |

## Verification
The bench builds the arbiter with NUM_SRC = 12 and 32-bit data. This gives two priority words, the second only half populated, so the word and slot decode is exercised across a word boundary. It also places the mask-set and mask-clear registers at addresses 2 and 3. Twelve sources allow level ties at several levels, a disabled source and the full 4-bit level range, up to 15, while the mask level is swept to below, equal to and above the winner.

// File: rtl/intc_pkg.sv
// Package: shared constants and helpers for the interrupt arbiter.
// Assumes: priority levels are unsigned; level 0 means "disabled".
package intc_pkg;

    // Kind of register addressed by a write
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_PRI  = 2'd1,
        RK_MSET = 2'd2,
        RK_MCLR = 2'd3
    } reg_kind_e;

    // Number of priority words needed for a given source count
    function automatic int pri_words(input int n_src, input int per_word);
        return (n_src + per_word - 1) / per_word;
    endfunction

endpackage

// File: rtl/intc_regs.sv
// Module: intc_regs
// Holds the per-source priority levels and the per-source mask bits.
// Priority words pack PER_WORD levels each. The mask-set register sets
// bits written 1, the mask-clear register clears bits written 1, and
// bits written 0 are untouched in both.
// Assumes: NUM_SRC <= DATA_W, DATA_W is a multiple of LVL_W, and
// ADDR_W can hold PRI_WORDS+1.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_SRC*LVL_W-1:0] pri_flat,
    output logic [NUM_SRC-1:0]       mask_q
);
    localparam int PER_WORD  = DATA_W / LVL_W;
    localparam int PRI_WORDS = pri_words(NUM_SRC, PER_WORD);
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(PRI_WORDS);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(PRI_WORDS + 1);

    reg_kind_e kind;

    // Classify the current write by address
    always_comb begin
        kind = RK_NONE;
        if (wr_en) begin
            if (wr_addr == SET_ADDR)      kind = RK_MSET;
            else if (wr_addr == CLR_ADDR) kind = RK_MCLR;
            else if (int'(wr_addr) < PRI_WORDS) kind = RK_PRI;
        end
    end

    // One priority register per source, decoded from word and slot
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pri
        localparam int WORD = i / PER_WORD;
        localparam int SLOT = i % PER_WORD;
        logic [LVL_W-1:0] lvl_q;

        // Load this source's level when its word is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (kind == RK_PRI && wr_addr == ADDR_W'(WORD))
                lvl_q <= wr_data[SLOT*LVL_W +: LVL_W];
        end

        assign pri_flat[i*LVL_W +: LVL_W] = lvl_q;
    end

    // Mask bits: write-1-to-set and write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (kind == RK_MSET)
            mask_q <= mask_q | wr_data[NUM_SRC-1:0];
        else if (kind == RK_MCLR)
            mask_q <= mask_q & ~wr_data[NUM_SRC-1:0];
    end

    AST_MSET_SETS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_MSET) |=> ((mask_q & $past(wr_data[NUM_SRC-1:0])) == $past(wr_data[NUM_SRC-1:0]))); // R6
    AST_MSET_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_MSET) |=> ((mask_q & ~$past(wr_data[NUM_SRC-1:0])) == ($past(mask_q) & ~$past(wr_data[NUM_SRC-1:0])))); // R6
    AST_MCLR_ZERO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_MCLR) |=> ((mask_q & ~$past(wr_data[NUM_SRC-1:0])) == ($past(mask_q) & ~$past(wr_data[NUM_SRC-1:0])))); // R8
    AST_MCLR_CLEARS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_MCLR) |=> ((mask_q & $past(wr_data[NUM_SRC-1:0])) == '0)); // R8

endmodule

// File: rtl/intc_select.sv
// Module: intc_select
// Combinational winner selection: the highest level among eligible
// sources; equal levels resolve to the lower index.
// Assumes: eligibility = request high, mask clear, level nonzero.
module intc_select #(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 4,
    parameter int IDX_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC-1:0]       mask_q,
    input  logic [NUM_SRC*LVL_W-1:0] pri_flat,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);
    logic [NUM_SRC-1:0] eligible;
    logic [LVL_W-1:0]   lvl [NUM_SRC];

    // Unpack each level and decide whether the source may compete
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign lvl[i]      = pri_flat[i*LVL_W +: LVL_W];
        assign eligible[i] = irq_req[i] && !mask_q[i] && (lvl[i] != '0);
    end

    // Scan from the top index down so a tie lands on the lower index
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i] && lvl[i] >= win_lvl) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = lvl[i];
            end
        end
    end

    AST_WINNER_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (irq_req[win_idx] && !mask_q[win_idx])); // R1
    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pri_flat[win_idx*LVL_W +: LVL_W] != '0)); // R7
    AST_NONE_WHEN_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~mask_q) == '0) |-> !win_valid); // R6

endmodule

// File: rtl/intc_out.sv
// Module: intc_out
// Compares the winning level with the CPU mask level and registers the
// request, level and event code sent to the CPU.
// Assumes: the event code is CODE_BASE + CODE_STEP * index and fits CODE_W.
module intc_out #(
    parameter int LVL_W     = 4,
    parameter int IDX_W     = 4,
    parameter int CODE_W    = 12,
    parameter int CODE_BASE = 'h200,
    parameter int CODE_STEP = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [LVL_W-1:0]  win_lvl,
    input  logic [LVL_W-1:0]  cpu_mask_lvl,
    output logic              cpu_req,
    output logic [LVL_W-1:0]  cpu_lvl,
    output logic [CODE_W-1:0] cpu_code
);
    logic              fwd;
    logic [CODE_W-1:0] code_nxt;

    // Strict compare against the CPU mask level
    always_comb fwd = win_valid && (win_lvl > cpu_mask_lvl);

    // Event code derived from the winner's index
    always_comb code_nxt = CODE_W'(CODE_BASE + CODE_STEP * int'(win_idx));

    // Register the outward request; idle values are all zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_req  <= 1'b0;
            cpu_lvl  <= '0;
            cpu_code <= '0;
        end else begin
            cpu_req  <= fwd;
            cpu_lvl  <= fwd ? win_lvl  : '0;
            cpu_code <= fwd ? code_nxt : '0;
        end
    end

    AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_lvl > $past(cpu_mask_lvl))); // R4
    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (cpu_lvl == '0 && cpu_code == '0)); // R4
    AST_NO_REQ_WITHOUT_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_valid) |-> !cpu_req); // R9

endmodule

// File: rtl/intc_arbiter.sv
// Module: intc_arbiter (top)
// Prioritized, maskable interrupt arbiter: software-programmed levels,
// write-1-to-set and write-1-to-clear source masks, a fixed low-index
// tie-break and a strict compare against the CPU mask level.
// Assumes: request lines are level-sensitive and synchronous to clk.
module intc_arbiter #(
    parameter int NUM_SRC   = 16,
    parameter int LVL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CODE_W    = 12,
    parameter int CODE_BASE = 'h200,
    parameter int CODE_STEP = 'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [LVL_W-1:0]   cpu_mask_lvl,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               cpu_req,
    output logic [LVL_W-1:0]   cpu_lvl,
    output logic [CODE_W-1:0]  cpu_code
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC*LVL_W-1:0] pri_flat;
    logic [NUM_SRC-1:0]       mask_q;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    logic [LVL_W-1:0]         win_lvl;

    intc_regs #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pri_flat (pri_flat),
        .mask_q   (mask_q)
    );

    intc_select #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) sel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .mask_q    (mask_q),
        .pri_flat  (pri_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    intc_out #(
        .LVL_W     (LVL_W),
        .IDX_W     (IDX_W),
        .CODE_W    (CODE_W),
        .CODE_BASE (CODE_BASE),
        .CODE_STEP (CODE_STEP)
    ) out_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_valid    (win_valid),
        .win_idx      (win_idx),
        .win_lvl      (win_lvl),
        .cpu_mask_lvl (cpu_mask_lvl),
        .cpu_req      (cpu_req),
        .cpu_lvl      (cpu_lvl),
        .cpu_code     (cpu_code)
    );

endmodule

// File: tb/intc_arbiter_tb.sv
// Bench for intc_arbiter with 12 sources: a vector table walked in one
// loop, then directed tests for reset, latency, pending and masks.
module intc_arbiter_tb_top;
    localparam int NS = 12;

    typedef struct packed {
        logic [NS-1:0] req;
        logic [3:0]    mlvl;
        logic          ereq;
        logic [3:0]    elvl;
        logic [11:0]   ecode;
    } vec_t;

    // Levels: s0=3 s1=5 s2=5 s3=0 s4=9 s5=2 s6=9 s7=1 s8=15 s9=7 s10=7 s11=4
    localparam vec_t VECS [13] = '{
        '{12'h000, 4'd0, 1'b0, 4'd0,  12'h000},  // nothing pending
        '{12'h001, 4'd0, 1'b1, 4'd3,  12'h200},  // R1 single source
        '{12'h006, 4'd0, 1'b1, 4'd5,  12'h220},  // R2 tie s1/s2
        '{12'h050, 4'd0, 1'b1, 4'd9,  12'h280},  // R2 tie s4/s6
        '{12'h008, 4'd0, 1'b0, 4'd0,  12'h000},  // R7 disabled source alone
        '{12'h009, 4'd0, 1'b1, 4'd3,  12'h200},  // R7 disabled loses to s0
        '{12'hFFF, 4'd0, 1'b1, 4'd15, 12'h300},  // R1 all requesting
        '{12'hE00, 4'd6, 1'b1, 4'd7,  12'h320},  // R4 above mask, R2 tie
        '{12'h600, 4'd7, 1'b0, 4'd0,  12'h000},  // R4 equal not forwarded
        '{12'h200, 4'd8, 1'b0, 4'd0,  12'h000},  // R4 below not forwarded
        '{12'h820, 4'd3, 1'b1, 4'd4,  12'h360},  // R5 code of s11
        '{12'h820, 4'd4, 1'b0, 4'd0,  12'h000},  // R4 winner equal to mask
        '{12'h080, 4'd0, 1'b1, 4'd1,  12'h2E0}   // R5 code of s7
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] irq_req;
    logic [3:0]    cpu_mask_lvl;
    logic          wr_en;
    logic [3:0]    wr_addr;
    logic [31:0]   wr_data;
    logic          cpu_req;
    logic [3:0]    cpu_lvl;
    logic [11:0]   cpu_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    intc_arbiter #(.NUM_SRC(NS), .DATA_W(32), .ADDR_W(4)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_req      (irq_req),
        .cpu_mask_lvl (cpu_mask_lvl),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cpu_req      (cpu_req),
        .cpu_lvl      (cpu_lvl),
        .cpu_code     (cpu_code)
    );

    task automatic check(input string tag, input logic er, input logic [3:0] el,
                         input logic [11:0] ec);
        checks++;
        if (cpu_req !== er || cpu_lvl !== el || cpu_code !== ec) begin
            errors++;
            $display("FAIL %s: got req=%0b lvl=%0d code=%h, expected req=%0b lvl=%0d code=%h",
                     tag, cpu_req, cpu_lvl, cpu_code, er, el, ec);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        rst_n = 1'b0; irq_req = '0; cpu_mask_lvl = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R10 outputs in reset", 1'b0, 4'd0, 12'h000);
        irq_req = '1;
        @(negedge clk);
        check("R10 requests ignored in reset", 1'b0, 4'd0, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 R7 priorities zero after reset", 1'b0, 4'd0, 12'h000);

        irq_req = 12'h001;
        wr_reg(4'd0, 32'h1929_0553);
        check("R9 write not yet visible", 1'b0, 4'd0, 12'h000);
        @(negedge clk);
        check("R9 R11 word0 level of s0", 1'b1, 4'd3, 12'h200);
        wr_reg(4'd1, 32'h0000_477F);

        for (int k = 0; k < 13; k++) begin
            irq_req      = VECS[k].req;
            cpu_mask_lvl = VECS[k].mlvl;
            @(negedge clk);
            check($sformatf("table row %0d (R1 R2 R4 R5 R7 R11)", k),
                  VECS[k].ereq, VECS[k].elvl, VECS[k].ecode);
        end

        irq_req = 12'h100;
        #2;
        check("R9 no change before edge", 1'b1, 4'd1, 12'h2E0);
        @(negedge clk);
        check("R9 R11 word1 level of s8", 1'b1, 4'd15, 12'h300);

        irq_req = 12'h110;
        @(negedge clk);
        check("R3 s8 wins over s4", 1'b1, 4'd15, 12'h300);
        irq_req = 12'h010;
        @(negedge clk);
        check("R3 pending s4 wins next", 1'b1, 4'd9, 12'h280);

        irq_req = 12'hFFF;
        @(negedge clk);
        wr_reg(4'd2, 32'h0000_0100);
        @(negedge clk);
        check("R6 s8 masked", 1'b1, 4'd9, 12'h280);
        wr_reg(4'd2, 32'h0000_0010);
        @(negedge clk);
        check("R6 s4 masked, s8 stays masked", 1'b1, 4'd9, 12'h2C0);
        wr_reg(4'd3, 32'h0000_0000);
        @(negedge clk);
        check("R8 clear with zeros no effect", 1'b1, 4'd9, 12'h2C0);
        wr_reg(4'd3, 32'h0000_0100);
        @(negedge clk);
        check("R8 clear unmasks s8", 1'b1, 4'd15, 12'h300);
        irq_req = 12'h050;
        @(negedge clk);
        check("R8 s4 still masked after s8 clear", 1'b1, 4'd9, 12'h2C0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule